// File: doc/BRIEF.md
# Microcode-Controlled Step Counter

This block holds one counter register and the adder that updates it. It can serve as the instruction address counter or the microinstruction address counter of a microcoded datapath. Control arrives as a four-bit packet strobed by an activation pulse. The packet says whether the adder sees the current count or zero on its first operand. It picks the constant one or an external value for the second operand. It also says whether the result goes out on the gated output.

Timing follows a two-phase scheme mapped onto a single clock. The edge that sees the activation latches the packet and the external value. During the following cycle the adder forms the sum, and the next edge writes that sum into the count register. Also at that edge, if the packet asked for it, the sum is loaded onto the gated output. The gated output carries the sum for exactly one cycle and reads zero at all other times, so it can share a wired-OR bus with other drivers. The feedback output always shows the register.

Top module: `step_counter_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cnt_q` and `gate_q` both become zero.
- R2: With `ctl_add_self`=1 and `ctl_step_one`=1, and `ctl_step_ext`=0, an activation sampled at edge N makes `cnt_q` equal to the old count plus one from edge N+1.
- R3: With `ctl_add_self`=1 and `ctl_step_ext`=1, `cnt_q` becomes the old count plus `ext_val` from edge N+1.
- R4: When `ctl_step_one` and `ctl_step_ext` are both 1, the external value is added and the constant one is not.
- R5: With `ctl_add_self`=0, the first adder operand is zero, so `cnt_q` is loaded with the selected second operand.
- R6: With `ctl_step_one`=0 and `ctl_step_ext`=0, the second adder operand is zero.
- R7: When `ctl_gate_en`=1, `gate_q` equals the new count during the single cycle after edge N+1 and returns to zero after that. When `ctl_gate_en`=0, `gate_q` stays zero.
- R8: With no activation, `cnt_q` holds its value and `gate_q` reads zero.
- R9: The sum wraps modulo 2^WIDTH.
- R10: `ext_val` is captured at the activation edge N. Changes to it after that edge do not affect the result.
- R11: Activations on consecutive edges chain: each one adds to the count written by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act | input | 1 | Activation strobe for the control packet |
| ctl_add_self | input | 1 | First adder operand is the count (1) or zero (0) |
| ctl_step_one | input | 1 | Second operand is the constant one |
| ctl_step_ext | input | 1 | Second operand is `ext_val` (wins over one) |
| ctl_gate_en | input | 1 | Drive the sum on `gate_q` |
| ext_val | input | WIDTH | External step or load value |
| cnt_q | output | WIDTH | Count register (feedback output) |
| gate_q | output | WIDTH | Gated sum output, zero when not driven |

## Verification
The hardest case to reach from the ports is two activations on adjacent edges. In that case the second sum must use a count written at the very edge that latches the second packet. The bench holds `act` high across two clock edges, so the two additions overlap with the register write. It then checks both the doubled step and the single-cycle pulse on the gated output. The capture of `ext_val` is tested by changing that input between the latch edge and the write edge.

// File: rtl/step_counter_pkg.sv
// Shared types for the step counter unit.
package step_counter_pkg;
    // Control packet carried from the activation edge to the write edge.
    typedef struct packed {
        logic add_self;
        logic step_one;
        logic step_ext;
        logic gate_en;
    } step_ctrl_t;
endpackage

// File: rtl/sc_packet_stage.sv
// Latches the control packet and external value on the activation edge.
// Assumes: synchronous active-low reset; one activation per edge at most.
module sc_packet_stage
    import step_counter_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  step_ctrl_t       ctrl_in,
    input  logic [WIDTH-1:0] ext_in,
    output logic             stg_vld,
    output step_ctrl_t       stg_ctrl,
    output logic [WIDTH-1:0] stg_ext
);
    // Capture the packet when strobed; the valid flag lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_vld  <= 1'b0;
            stg_ctrl <= '0;
            stg_ext  <= '0;
        end else begin
            stg_vld <= act;
            if (act) begin
                stg_ctrl <= ctrl_in;
                stg_ext  <= ext_in;
            end
        end
    end

    AST_VLD_FOLLOWS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> stg_vld); // R11
endmodule

// File: rtl/sc_operand_sel.sv
// Picks the two adder operands from the latched packet.
// Assumes: the external step has priority over the constant one.
module sc_operand_sel
    import step_counter_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  step_ctrl_t       stg_ctrl,
    input  logic [WIDTH-1:0] count,
    input  logic [WIDTH-1:0] stg_ext,
    output logic [WIDTH-1:0] op_a,
    output logic [WIDTH-1:0] op_b
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // First operand: the count itself, or zero so that the packet loads a value.
    always_comb op_a = stg_ctrl.add_self ? count : '0;

    // Second operand: external, else one, else zero.
    always_comb begin
        if (stg_ctrl.step_ext)      op_b = stg_ext;
        else if (stg_ctrl.step_one) op_b = ONE;
        else                        op_b = '0;
    end

    AST_EXT_PRIORITY: assert final (!(stg_ctrl.step_ext) || op_b == stg_ext); // R4
endmodule

// File: rtl/sc_accum_reg.sv
// Adds the operands, writes the count and drives the gated sum output.
// Assumes: the sum wraps at 2^WIDTH; the gated output is zero when idle.
module sc_accum_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stg_vld,
    input  logic             gate_en,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] count,
    output logic [WIDTH-1:0] gate_out
);
    logic [WIDTH-1:0] sum;

    // Modulo adder for the write-back value.
    always_comb sum = op_a + op_b;

    // Write the count on every activation; otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (stg_vld) count <= sum;
    end

    // Present the sum on the gated output for one cycle when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                  gate_out <= '0;
        else if (stg_vld && gate_en) gate_out <= sum;
        else                         gate_out <= '0;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && gate_out == '0)); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !stg_vld |=> $stable(count)); // R8
    AST_GATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(stg_vld && gate_en) |=> gate_out == '0); // R7
    AST_GATE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_vld && gate_en) |=> gate_out == count); // R7
endmodule

// File: rtl/step_counter_unit.sv
// Top of the step counter: a packet stage, an operand selector and the accumulating register.
// Assumes: control fields are sampled only while act is high.
module step_counter_unit
    import step_counter_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic             ctl_add_self,
    input  logic             ctl_step_one,
    input  logic             ctl_step_ext,
    input  logic             ctl_gate_en,
    input  logic [WIDTH-1:0] ext_val,
    output logic [WIDTH-1:0] cnt_q,
    output logic [WIDTH-1:0] gate_q
);
    step_ctrl_t       ctrl_in;
    step_ctrl_t       stg_ctrl;
    logic             stg_vld;
    logic [WIDTH-1:0] stg_ext;
    logic [WIDTH-1:0] op_a;
    logic [WIDTH-1:0] op_b;

    // Pack the loose control pins into the packet type.
    always_comb ctrl_in = '{add_self: ctl_add_self, step_one: ctl_step_one,
                            step_ext: ctl_step_ext, gate_en: ctl_gate_en};

    sc_packet_stage #(.WIDTH(WIDTH)) u_stage (
        .clk(clk), .rst_n(rst_n), .act(act), .ctrl_in(ctrl_in), .ext_in(ext_val),
        .stg_vld(stg_vld), .stg_ctrl(stg_ctrl), .stg_ext(stg_ext)
    );

    sc_operand_sel #(.WIDTH(WIDTH)) u_sel (
        .stg_ctrl(stg_ctrl), .count(cnt_q), .stg_ext(stg_ext),
        .op_a(op_a), .op_b(op_b)
    );

    sc_accum_reg #(.WIDTH(WIDTH)) u_acc (
        .clk(clk), .rst_n(rst_n), .stg_vld(stg_vld), .gate_en(stg_ctrl.gate_en),
        .op_a(op_a), .op_b(op_b), .count(cnt_q), .gate_out(gate_q)
    );

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (act && ctl_add_self && ctl_step_one && !ctl_step_ext)
        |=> ##1 cnt_q == $past(cnt_q) + WIDTH'(1)); // R2
endmodule

// File: tb/step_counter_unit_tb_top.sv
module step_counter_unit_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         act = 1'b0;
    logic         c_self = 1'b0, c_one = 1'b0, c_ext = 1'b0, c_gate = 1'b0;
    logic [W-1:0] ext_val = '0;
    logic [W-1:0] cnt_q, gate_q;
    int           n_run = 0, n_fail = 0;
    logic [W-1:0] base;

    always #5 clk = ~clk;

    step_counter_unit #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .act(act),
        .ctl_add_self(c_self), .ctl_step_one(c_one), .ctl_step_ext(c_ext),
        .ctl_gate_en(c_gate), .ext_val(ext_val), .cnt_q(cnt_q), .gate_q(gate_q)
    );

    task automatic check(input string req, input logic [W-1:0] act_v, input logic [W-1:0] exp_v);
        n_run++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act_v, exp_v);
        end
    endtask

    // One activation driven at a negedge; returns at the negedge after the write edge.
    task automatic activate(input logic s, input logic o, input logic e, input logic g,
                            input logic [W-1:0] v);
        @(negedge clk);
        act = 1'b1; c_self = s; c_one = o; c_ext = e; c_gate = g; ext_val = v;
        @(negedge clk);
        act = 1'b0; c_self = 1'b0; c_one = 1'b0; c_ext = 1'b0; c_gate = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 count", cnt_q, '0);
        check("R1 gate", gate_q, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_increment;
        base = cnt_q;
        activate(1, 1, 0, 1, 16'h0);
        check("R2 inc", cnt_q, base + 16'd1);
        check("R7 gate pulse", gate_q, base + 16'd1);
        @(negedge clk);
        check("R7 gate back to zero", gate_q, '0);
    endtask

    task automatic t_ext_add;
        base = cnt_q;
        activate(1, 0, 1, 0, 16'h0120);
        check("R3 ext add", cnt_q, base + 16'h0120);
        check("R7 gate disabled", gate_q, '0);
    endtask

    task automatic t_priority;
        base = cnt_q;
        activate(1, 1, 1, 0, 16'h0005);
        check("R4 ext wins", cnt_q, base + 16'h0005);
    endtask

    task automatic t_load;
        activate(0, 0, 1, 1, 16'hFFFE);
        check("R5 load", cnt_q, 16'hFFFE);
        check("R5 load gate", gate_q, 16'hFFFE);
    endtask

    task automatic t_wrap;
        activate(1, 1, 0, 0, 16'h0);
        check("R9 to max", cnt_q, 16'hFFFF);
        activate(1, 1, 0, 0, 16'h0);
        check("R9 wrap", cnt_q, 16'h0000);
    endtask

    task automatic t_zero_step;
        activate(0, 0, 1, 0, 16'h0042);
        activate(1, 0, 0, 1, 16'h0777);
        check("R6 zero step", cnt_q, 16'h0042);
        check("R6 zero step gate", gate_q, 16'h0042);
    endtask

    task automatic t_hold;
        base = cnt_q;
        ext_val = 16'h1234;
        repeat (5) @(negedge clk);
        check("R8 hold", cnt_q, base);
        check("R8 gate idle", gate_q, '0);
    endtask

    task automatic t_capture;
        base = cnt_q;
        @(negedge clk);
        act = 1'b1; c_self = 1'b1; c_ext = 1'b1; ext_val = 16'h0010;
        @(negedge clk);
        act = 1'b0; c_self = 1'b0; c_ext = 1'b0; ext_val = 16'h7000;
        @(negedge clk);
        check("R10 captured ext", cnt_q, base + 16'h0010);
    endtask

    task automatic t_back_to_back;
        base = cnt_q;
        @(negedge clk);
        act = 1'b1; c_self = 1'b1; c_one = 1'b1; c_gate = 1'b1;
        @(negedge clk);
        @(negedge clk);
        act = 1'b0; c_self = 1'b0; c_one = 1'b0; c_gate = 1'b0;
        check("R11 first step", cnt_q, base + 16'd1);
        check("R11 first gate", gate_q, base + 16'd1);
        @(negedge clk);
        check("R11 chained", cnt_q, base + 16'd2);
        check("R11 chained gate", gate_q, base + 16'd2);
        @(negedge clk);
        check("R11 gate ends", gate_q, '0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_increment();
        t_ext_add();
        t_priority();
        t_load();
        t_wrap();
        t_zero_step();
        t_hold();
        t_capture();
        t_back_to_back();
        t_reset();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule